// File: doc/BRIEF.md
# Satellite Control Tone Transmitter

This block drives the 22 kHz control tone that a satellite receiver sends down its antenna cable to steer dish switches. Software loads a short command (three to six bytes) into a small buffer, picks message or burst operation in a mode register, and launches the job through one control register. The block then gates a square-wave carrier on and off using pulse-width keying. Each bit lasts three time units. A zero is two units of tone followed by one unit of silence. A one is one unit of tone followed by two units of silence. Every byte goes out MSB first and is followed by an odd parity bit. A single-shot burst is also available: either an unbroken stretch of tone, or nine keyed ones.

The control register has three jobs. It holds a steady-tone enable. Writing its go bit starts a job. Reading that same bit returns 1 when the block can accept a new job. A job is refused while the steady tone is requested. After any job the line stays silent for a guard period before the block reports ready again. One time unit (nominally 0.5 ms) and one carrier half period are both set in clock cycles through parameters.

Top module: `dsq_tx`

## Requirements
- R1: After reset the control register reads 0x40 (ready, all other bits clear), the mode register reads 0, every buffer byte reads 0 and `tone_out` is low.
- R2: Buffer byte i (i = 0..5) sits at address 0x8+i and reads back what was written. The 2-bit length code in control bits 1:0 sends code+3 bytes, starting from byte 0.
- R3: Writing control (address 0x0) with bit 6 set starts a job only when three conditions hold: the block is ready, bit 4 of the written value is 0, and the mode is 0 or 4. Control bit 6 reads 0 from the cycle after the starting write until the job ends.
- R4: In message mode (mode 0) each bit occupies 3 units. A 0 is tone for 2 units, then silence for 1. A 1 is tone for 1 unit, then silence for 2. Each byte is sent MSB first and followed by an odd parity bit.
- R5: In burst mode (mode 4) with control bit 3 = 0, the output carries 25 units of unbroken tone.
- R6: In burst mode with control bit 3 = 1, the output carries nine keyed 1-bits.
- R7: Every job ends with 30 units of silence. Control bit 6 reads 1 in the first cycle after that silence.
- R8: While the block is ready and control bit 4 is set, the carrier runs on `tone_out` without a break. A start write whose bit 4 is set is refused and leaves the block ready.
- R9: While a job runs, writes to the buffer, to the mode register and to control are ignored, and the running job is not disturbed.
- R10: Control bits 7, 4, 3 and 1:0 store the written value and read back. Bit 6 reads the ready state. Bits 5 and 2 read 0.
- R11: The mode register at address 0x1 is 3 bits wide. Any mode value other than 0 or 4 makes a start write do nothing.
- R12: `tone_out` is high in the first cycle of every gated stretch, toggles every half-period while gated, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tone_out | output | 1 | Gated carrier toward the cable driver |

## Verification
A starting write takes effect at the clock edge that samples it. Carrier gating and the ready bit both change in the very next cycle, because gating is combinational from the sequencer state. Each unit therefore covers exactly UNIT_CYC cycles, counted from the first falling edge after that write. The bench queues one expected envelope value per unit and has a monitor sample each unit over precisely those falling edges. The ready bit is sampled at the first cycle of each unit and again in the cycle after the last guard unit. Steady-tone and carrier-phase checks sample `tone_out` cycle by cycle, starting in the cycle right after the control write.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    localparam int LEN_W         = 2;
    localparam int MIN_LEN       = 3;
    localparam int BUF_DEPTH     = MIN_LEN + (1 << LEN_W) - 1;
    localparam int SYM_SLOTS     = 3;
    localparam int BITS_PER_CHAR = 9;
    localparam int ADDR_W        = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_BUF  = 4'h8;

    localparam logic [2:0] MODE_MSG   = 3'd0;
    localparam logic [2:0] MODE_BURST = 3'd4;

    typedef enum logic [1:0] {ST_IDLE, ST_SYM, ST_BURST, ST_GAP} seq_state_t;
    typedef enum logic [1:0] {JOB_MSG, JOB_TONE_A, JOB_TONE_B} job_kind_t;

    typedef struct packed {
        job_kind_t  kind;
        logic [2:0] nbytes;
    } job_t;

    typedef struct packed {
        logic             spare;
        logic             tone;
        logic             bsel;
        logic [LEN_W-1:0] len;
    } ctrl_t;

    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

    // tone slots at the start of a 3-slot bit cell
    function automatic logic [1:0] on_slots(input logic v);
        return v ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/dsq_regs.sv
module dsq_regs
    import dsq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    input  logic                   busy,
    output logic [7:0]             rdata,
    output ctrl_t                  ctrl,
    output logic [BUF_DEPTH*8-1:0] bufs,
    output logic                   start,
    output job_t                   job
);
    localparam logic [ADDR_W-1:0] BUF_END = ADDR_BUF + ADDR_W'(BUF_DEPTH);

    logic [2:0] mode_q;
    ctrl_t      ctrl_q;
    logic       wr_ok;
    logic       in_buf;
    logic [2:0] buf_idx;

    assign wr_ok   = wr_en && !busy;
    assign in_buf  = (addr >= ADDR_BUF) && (addr < BUF_END);
    assign buf_idx = 3'(addr - ADDR_BUF);

    generate
        for (genvar i = 0; i < BUF_DEPTH; i++) begin : g_buf
            logic [7:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)
                    byte_q <= '0;
                else if (wr_ok && addr == ADDR_BUF + ADDR_W'(i))
                    byte_q <= wdata;
            end
            assign bufs[i*8 +: 8] = byte_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_MSG;
            ctrl_q <= '0;
        end else if (wr_ok) begin
            if (addr == ADDR_MODE)
                mode_q <= wdata[2:0];
            if (addr == ADDR_CTRL)
                ctrl_q <= '{spare: wdata[7], tone: wdata[4], bsel: wdata[3],
                            len: wdata[LEN_W-1:0]};
        end
    end

    assign start = wr_ok && addr == ADDR_CTRL && wdata[6] && !wdata[4]
                   && (mode_q == MODE_MSG || mode_q == MODE_BURST);

    always_comb begin
        job.kind   = JOB_MSG;
        job.nbytes = 3'(wdata[LEN_W-1:0]) + 3'(MIN_LEN);
        if (mode_q == MODE_BURST) begin
            job.kind   = wdata[3] ? JOB_TONE_B : JOB_TONE_A;
            job.nbytes = 3'd1;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL)
            rdata = {ctrl_q.spare, ~busy, 1'b0, ctrl_q.tone, ctrl_q.bsel, 1'b0, ctrl_q.len};
        else if (addr == ADDR_MODE)
            rdata = {5'b0, mode_q};
        else if (in_buf)
            rdata = bufs[int'(buf_idx)*8 +: 8];
    end

    assign ctrl = ctrl_q;

    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));
    p_ctrl_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctrl_q));

endmodule

// File: rtl/dsq_seq.sv
module dsq_seq
    import dsq_pkg::*;
#(
    parameter int UNIT_CYC      = 13500,
    parameter int BURST_A_UNITS = 25,
    parameter int GAP_UNITS     = 30
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  job_t                   job_in,
    input  logic [BUF_DEPTH*8-1:0] bufs,
    output logic                   busy,
    output logic                   gate
);
    localparam int LONGEST = (BURST_A_UNITS > GAP_UNITS) ? BURST_A_UNITS : GAP_UNITS;
    localparam int UCW     = $clog2(UNIT_CYC + 1);
    localparam int UUW     = $clog2(LONGEST + 1);

    seq_state_t     state;
    job_t           job_q;
    logic [UCW-1:0] ucnt;
    logic [UUW-1:0] uunits;
    logic [1:0]     slot;
    logic [3:0]     bidx;
    logic [2:0]     byidx;
    logic           tick;
    logic [7:0]     cur_byte;
    logic           cur_bit;
    logic           last_bit;
    logic           last_byte;

    assign tick      = ucnt == UCW'(UNIT_CYC - 1);
    assign cur_byte  = bufs[int'(byidx)*8 +: 8];
    assign last_bit  = bidx == 4'(BITS_PER_CHAR - 1);
    assign last_byte = byidx == job_q.nbytes - 3'd1;

    always_comb begin
        if (job_q.kind == JOB_TONE_B)
            cur_bit = 1'b1;
        else if (last_bit)
            cur_bit = odd_parity(cur_byte);
        else
            cur_bit = cur_byte[3'd7 - bidx[2:0]];
    end

    always_comb begin
        case (state)
            ST_SYM:   gate = slot < on_slots(cur_bit);
            ST_BURST: gate = 1'b1;
            default:  gate = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            job_q  <= '0;
            ucnt   <= '0;
            uunits <= '0;
            slot   <= '0;
            bidx   <= '0;
            byidx  <= '0;
        end else if (state == ST_IDLE) begin
            ucnt   <= '0;
            uunits <= '0;
            slot   <= '0;
            bidx   <= '0;
            byidx  <= '0;
            if (start) begin
                job_q <= job_in;
                state <= (job_in.kind == JOB_TONE_A) ? ST_BURST : ST_SYM;
            end
        end else begin
            ucnt <= tick ? '0 : ucnt + 1'b1;
            if (tick) begin
                case (state)
                    ST_SYM: begin
                        if (slot == 2'(SYM_SLOTS - 1)) begin
                            slot <= '0;
                            if (last_bit) begin
                                bidx <= '0;
                                if (last_byte) begin
                                    state  <= ST_GAP;
                                    uunits <= '0;
                                end else begin
                                    byidx <= byidx + 1'b1;
                                end
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                    ST_BURST: begin
                        if (uunits == UUW'(BURST_A_UNITS - 1)) begin
                            state  <= ST_GAP;
                            uunits <= '0;
                        end else begin
                            uunits <= uunits + 1'b1;
                        end
                    end
                    default: begin
                        if (uunits == UUW'(GAP_UNITS - 1))
                            state <= ST_IDLE;
                        else
                            uunits <= uunits + 1'b1;
                    end
                endcase
            end
        end
    end

    assign busy = state != ST_IDLE;

    p_byte_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SYM) |-> (byidx < job_q.nbytes));
    p_cell_slots_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SYM) |-> (slot < 2'(SYM_SLOTS)));
    p_gap_to_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && tick && uunits == UUW'(GAP_UNITS - 1)) |=> !busy);

endmodule

// File: rtl/dsq_carrier.sv
module dsq_carrier #(
    parameter int HALF_CYC = 614
) (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic tone_out
);
    localparam int HW = $clog2(HALF_CYC + 1);

    logic [HW-1:0] hcnt;
    logic          phase;

    always_ff @(posedge clk) begin
        if (rst || !gate) begin
            hcnt  <= '0;
            phase <= 1'b1;
        end else if (hcnt == HW'(HALF_CYC - 1)) begin
            hcnt  <= '0;
            phase <= ~phase;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assign tone_out = gate & phase;

    p_first_cycle_high_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> tone_out);

endmodule

// File: rtl/dsq_tx.sv
module dsq_tx
    import dsq_pkg::*;
#(
    parameter int UNIT_CYC      = 13500,
    parameter int HALF_CYC      = 614,
    parameter int BURST_A_UNITS = 25,
    parameter int GAP_UNITS     = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              tone_out
);
    ctrl_t                  ctrl;
    logic [BUF_DEPTH*8-1:0] bufs;
    logic                   start;
    job_t                   job;
    logic                   busy;
    logic                   seq_gate;
    logic                   gate;

    dsq_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .rdata(rdata), .ctrl(ctrl), .bufs(bufs),
        .start(start), .job(job)
    );

    dsq_seq #(
        .UNIT_CYC(UNIT_CYC), .BURST_A_UNITS(BURST_A_UNITS), .GAP_UNITS(GAP_UNITS)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .job_in(job), .bufs(bufs),
        .busy(busy), .gate(seq_gate)
    );

    assign gate = seq_gate | (!busy & ctrl.tone);

    dsq_carrier #(.HALF_CYC(HALF_CYC)) u_car (
        .clk(clk), .rst(rst), .gate(gate), .tone_out(tone_out)
    );

    p_no_steady_tone_in_job_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ctrl.tone);
    p_refused_start_stays_ready_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en && addr == ADDR_CTRL && wdata[4]) |=> !busy);

endmodule

// File: tb/dsq_tx_tb.sv
module dsq_tx_tb;
    import dsq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int U          = 4;
    localparam int BAU        = 25;
    localparam int GAPU       = 30;
    localparam int WD_CYCLES  = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       tone_out;

    int    checks = 0;
    int    fails  = 0;
    bit    exp_q[$];
    string cur_req;
    event  go, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsq_tx #(.UNIT_CYC(U), .HALF_CYC(1), .BURST_A_UNITS(BAU), .GAP_UNITS(GAPU)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tone_out(tone_out)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = ADDR_CTRL;
    endtask

    task automatic rd_chk(logic [3:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata == exp, req, "readback", rdata, exp);
        addr = ADDR_CTRL;
    endtask

    task automatic push_sym(bit v);
        exp_q.push_back(1'b1);
        exp_q.push_back(!v);
        exp_q.push_back(1'b0);
    endtask

    task automatic push_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) push_sym(b[i]);
        push_sym(~(^b));
    endtask

    task automatic push_gap();
        for (int i = 0; i < GAPU; i++) exp_q.push_back(1'b0);
    endtask

    // driver: launch a job already queued in exp_q, optionally poke registers mid-job
    task automatic launch(string req, logic [7:0] ctl, bit meddle);
        cur_req = req;
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_CTRL; wdata = ctl;
        @(posedge clk);
        ->go;
        @(negedge clk);
        wr_en = 1'b0;
        if (meddle) begin
            repeat (10) @(negedge clk);
            wr_en = 1'b1; addr = ADDR_BUF; wdata = 8'hFF;
            @(negedge clk); addr = ADDR_MODE; wdata = 8'h04;
            @(negedge clk); addr = ADDR_CTRL; wdata = 8'h5B;
            @(negedge clk); wr_en = 1'b0; addr = ADDR_CTRL;
        end
        @done;
    endtask

    // monitor: one envelope check per unit, ready bit at each unit start
    initial begin
        forever begin
            @go;
            while (exp_q.size() > 0) begin
                bit e;
                bit any;
                e   = exp_q.pop_front();
                any = 1'b0;
                for (int k = 0; k < U; k++) begin
                    @(negedge clk);
                    any |= tone_out;
                    if (k == 0 && addr == ADDR_CTRL && !wr_en)
                        chk(rdata[6] == 1'b0, "R3", "ready during job", rdata[6], 0);
                end
                chk(any == e, cur_req, "unit envelope", any, e);
            end
            @(negedge clk);
            chk(rdata[6] == 1'b1, "R7", "ready after guard", rdata[6], 1);
            chk(tone_out == 1'b0, "R7", "silence after guard", tone_out, 0);
            ->done;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] m3[3] = '{8'hE0, 8'h10, 8'h38};
        logic [7:0] m6[6] = '{8'hE0, 8'h31, 8'h6B, 8'hF0, 8'h00, 8'h5A};
        rst = 1'b1; wr_en = 1'b0; addr = ADDR_CTRL; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk(rdata == 8'h40, "R1", "ctrl after reset", rdata, 8'h40);
        chk(tone_out == 1'b0, "R1", "tone after reset", tone_out, 0);
        rd_chk(ADDR_MODE, 8'h00, "R1");
        rd_chk(ADDR_BUF + 4'd5, 8'h00, "R1");

        // R10 field storage
        wr_reg(ADDR_CTRL, 8'hA9);
        rd_chk(ADDR_CTRL, 8'hC9, "R10");
        wr_reg(ADDR_CTRL, 8'h00);

        // R2 buffer readback, R4 three-byte message
        for (int i = 0; i < 3; i++) wr_reg(ADDR_BUF + 4'(i), m3[i]);
        rd_chk(ADDR_BUF + 4'd1, 8'h10, "R2");
        foreach (m3[i]) push_byte(m3[i]);
        push_gap();
        launch("R4", 8'h40, 1'b0);
        rd_chk(ADDR_CTRL, 8'h40, "R3");

        // R2 six-byte message, R9 writes during the job are ignored
        for (int i = 0; i < 6; i++) wr_reg(ADDR_BUF + 4'(i), m6[i]);
        foreach (m6[i]) push_byte(m6[i]);
        push_gap();
        launch("R2", 8'hC3, 1'b1);
        rd_chk(ADDR_BUF, 8'hE0, "R9");
        rd_chk(ADDR_MODE, 8'h00, "R9");
        rd_chk(ADDR_CTRL, 8'hC3, "R10");

        // R5 burst A
        wr_reg(ADDR_MODE, 8'h04);
        for (int i = 0; i < BAU; i++) exp_q.push_back(1'b1);
        push_gap();
        launch("R5", 8'h40, 1'b0);

        // R6 burst B
        for (int i = 0; i < 9; i++) push_sym(1'b1);
        push_gap();
        launch("R6", 8'h48, 1'b0);

        // R8 steady tone, refused start; R12 carrier phase
        wr_reg(ADDR_CTRL, 8'h50);
        chk(tone_out == 1'b1, "R12", "first gated cycle", tone_out, 1);
        @(negedge clk); chk(tone_out == 1'b0, "R12", "toggle 1", tone_out, 0);
        @(negedge clk); chk(tone_out == 1'b1, "R12", "toggle 2", tone_out, 1);
        @(negedge clk); chk(tone_out == 1'b0, "R12", "toggle 3", tone_out, 0);
        repeat (8) @(negedge clk);
        chk(rdata == 8'h50, "R8", "ctrl with steady tone", rdata, 8'h50);
        wr_reg(ADDR_CTRL, 8'h00);
        repeat (3) @(negedge clk);
        chk(tone_out == 1'b0, "R12", "tone off", tone_out, 0);

        // R11 unsupported mode refuses start
        wr_reg(ADDR_MODE, 8'h02);
        rd_chk(ADDR_MODE, 8'h02, "R11");
        wr_reg(ADDR_CTRL, 8'h40);
        repeat (6) @(negedge clk);
        chk(rdata[6] == 1'b1, "R11", "still ready", rdata[6], 1);
        chk(tone_out == 1'b0, "R11", "no output", tone_out, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule